// File: doc/BRIEF.md
# Register-Access Redirection Unit

This unit sits beside the system-register path of a core that can host a nested hypervisor. Each system-register access arrives with a register identifier, a direction, write data and the privilege context of the code making it. The unit picks one of three outcomes for the access:

- **Redirect.** The access is sent to memory as a load or store. The address is a programmable page base plus a fixed offset for that register.
- **Trap.** A trap is raised with a syndrome, and no memory traffic is produced.
- **Pass.** The access goes on unchanged to the normal register path.

Redirection applies only when the deferred-state mode is on and the requester is a guest hypervisor. Two kinds of register are redirected: lower-level context registers, and hypervisor-level registers that only shape the lower-level environment. Timer control and timer compare registers are in the redirect table. The two relative timer-value registers are not, because they alias the compare state. Redirecting both views would leave two stale copies, so those two registers always trap.

The requester is stalled while a memory access is in progress. For a write, a response strobe marks completion. For a read, the response strobe comes with the loaded 64-bit value.

Top module: `sysreg_redirect`

## Requirements
- R1: With `mode_en`=1 and `acc_ctx`=2 (guest hypervisor), an access to a lower-level context register issues one memory request at address `base_q`+offset. The table includes id 0x01→0x110, 0x02→0x200 and 0x04→0x120.
- R2: Under the same conditions, the hypervisor-level ids 0x20→0x050 and 0x21→0x088 are redirected to memory.
- R3: Under the same conditions, the timer registers 0x10→0x180, 0x11→0x178, 0x13→0x170 and 0x14→0x168 (control and compare) are redirected to memory.
- R4: A guest-hypervisor access to the relative timer ids 0x12 or 0x15 always traps, whatever the value of `mode_en`, and no memory request is made for it.
- R5: With `mode_en`=0, a guest-hypervisor access to any redirected-table id traps instead of going to memory.
- R6: A trap is a one-cycle `trap_valid` pulse in the cycle after acceptance. `trap_syndrome` carries bit 6 = direction (1 = write) and bits 5:0 = register id.
- R7: An id that is not in the table, or any access with `acc_ctx`≠2, produces a one-cycle `pass_valid` pulse and no trap and no memory request.
- R8: `base_q` takes the value written through `base_wr`/`base_wdata`, with bits 11:0 read as zero. After reset it is zero.
- R9: A redirected write drives `mem_we`=1 with the requester's data. It completes with one `rsp_valid` pulse after the memory handshake.
- R10: A redirected read holds `acc_ready` low until `mem_rvalid`. It then returns `mem_rdata` on `rsp_rdata` with a `rsp_valid` pulse.
- R11: After reset, `acc_ready`=1 and `mem_valid`, `trap_valid`, `pass_valid` and `rsp_valid` are all 0.
- R12: While `mem_valid`=1 and `mem_ready`=0, the request address, data and direction stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | Deferred-state mode enable |
| base_wr | input | 1 | Write strobe for the base-address register |
| base_wdata | input | ADDR_W | New base value (low 12 bits dropped) |
| base_q | output | ADDR_W | Current base value |
| acc_valid | input | 1 | Register access request |
| acc_ready | output | 1 | Unit can accept an access |
| acc_id | input | ID_W | Register identifier |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | DATA_W | Write data |
| acc_ctx | input | 2 | Context: 0 user, 1 kernel, 2 guest hypervisor, 3 host hypervisor |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | ADDR_W | Request address |
| mem_we | output | 1 | Request is a store |
| mem_wdata | output | DATA_W | Store data |
| mem_rvalid | input | 1 | Load data valid |
| mem_rdata | input | DATA_W | Load data |
| trap_valid | output | 1 | Trap strobe |
| trap_syndrome | output | ID_W+1 | Direction and register id of the trapped access |
| pass_valid | output | 1 | Access goes to the normal register path |
| rsp_valid | output | 1 | Redirected access completed |
| rsp_rdata | output | DATA_W | Loaded value for a redirected read |

## Verification
Internal state can go wrong in a few ways, and each shows up at the ports within a few cycles of acceptance:

- **Wrong table entry.** The memory address seen at the first request cycle is wrong, or a trap or pass pulse appears where a request was due.
- **Stuck sequencer.** `acc_ready` stays low, or `rsp_valid` never follows the load data.
- **Corrupted held request.** The address moves while the memory stalls.

The vectors cover every outcome class in both mode settings and across contexts. A stalled read shows whether the request is held and whether the requester is blocked.

// File: rtl/srr_pkg.sv
package srr_pkg;

  localparam int REG_ID_W = 6;

  typedef enum logic [1:0] {
    CLS_PASS  = 2'd0,
    CLS_REDIR = 2'd1,
    CLS_TRAP  = 2'd2
  } reg_cls_e;

  typedef enum logic [1:0] {
    CTX_USER      = 2'd0,
    CTX_KERNEL    = 2'd1,
    CTX_GUEST_HYP = 2'd2,
    CTX_HOST_HYP  = 2'd3
  } ctx_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MREQ  = 2'd1,
    ST_RWAIT = 2'd2
  } seq_st_e;

  // lower-level context registers
  localparam logic [5:0] RID_SYS_CTL      = 6'h01;
  localparam logic [5:0] RID_XLAT_BASE0   = 6'h02;
  localparam logic [5:0] RID_XLAT_BASE1   = 6'h03;
  localparam logic [5:0] RID_XLAT_CTL     = 6'h04;
  localparam logic [5:0] RID_MEM_ATTR     = 6'h05;
  localparam logic [5:0] RID_VEC_BASE     = 6'h06;
  localparam logic [5:0] RID_EXC_RET      = 6'h07;
  localparam logic [5:0] RID_SAVED_PS     = 6'h08;
  localparam logic [5:0] RID_FAULT_SYN    = 6'h09;
  localparam logic [5:0] RID_FAULT_ADDR   = 6'h0A;
  // timers
  localparam logic [5:0] RID_PTMR_CTL     = 6'h10;
  localparam logic [5:0] RID_PTMR_CMP     = 6'h11;
  localparam logic [5:0] RID_PTMR_REL     = 6'h12;
  localparam logic [5:0] RID_VTMR_CTL     = 6'h13;
  localparam logic [5:0] RID_VTMR_CMP     = 6'h14;
  localparam logic [5:0] RID_VTMR_REL     = 6'h15;
  // hypervisor-level registers that only shape the lower-level view
  localparam logic [5:0] RID_VIRT_CORE_ID = 6'h20;
  localparam logic [5:0] RID_VIRT_PROC_ID = 6'h21;

endpackage

// File: rtl/srr_lookup.sv
module srr_lookup
  import srr_pkg::*;
#(
  parameter int ID_W  = REG_ID_W,
  parameter int OFF_W = 12
) (
  input  logic [ID_W-1:0]  reg_id,
  output reg_cls_e         cls,
  output logic [OFF_W-1:0] off
);

  always_comb begin
    cls = CLS_PASS;
    off = '0;
    case (reg_id)
      ID_W'(RID_SYS_CTL):      begin cls = CLS_REDIR; off = OFF_W'(12'h110); end
      ID_W'(RID_XLAT_BASE0):   begin cls = CLS_REDIR; off = OFF_W'(12'h200); end
      ID_W'(RID_XLAT_BASE1):   begin cls = CLS_REDIR; off = OFF_W'(12'h210); end
      ID_W'(RID_XLAT_CTL):     begin cls = CLS_REDIR; off = OFF_W'(12'h120); end
      ID_W'(RID_MEM_ATTR):     begin cls = CLS_REDIR; off = OFF_W'(12'h240); end
      ID_W'(RID_VEC_BASE):     begin cls = CLS_REDIR; off = OFF_W'(12'h250); end
      ID_W'(RID_EXC_RET):      begin cls = CLS_REDIR; off = OFF_W'(12'h230); end
      ID_W'(RID_SAVED_PS):     begin cls = CLS_REDIR; off = OFF_W'(12'h160); end
      ID_W'(RID_FAULT_SYN):    begin cls = CLS_REDIR; off = OFF_W'(12'h138); end
      ID_W'(RID_FAULT_ADDR):   begin cls = CLS_REDIR; off = OFF_W'(12'h220); end
      ID_W'(RID_PTMR_CTL):     begin cls = CLS_REDIR; off = OFF_W'(12'h180); end
      ID_W'(RID_PTMR_CMP):     begin cls = CLS_REDIR; off = OFF_W'(12'h178); end
      ID_W'(RID_VTMR_CTL):     begin cls = CLS_REDIR; off = OFF_W'(12'h170); end
      ID_W'(RID_VTMR_CMP):     begin cls = CLS_REDIR; off = OFF_W'(12'h168); end
      // relative timer views alias the compare state: never stored in memory (R4)
      ID_W'(RID_PTMR_REL):     begin cls = CLS_TRAP;  off = '0; end
      ID_W'(RID_VTMR_REL):     begin cls = CLS_TRAP;  off = '0; end
      ID_W'(RID_VIRT_CORE_ID): begin cls = CLS_REDIR; off = OFF_W'(12'h050); end
      ID_W'(RID_VIRT_PROC_ID): begin cls = CLS_REDIR; off = OFF_W'(12'h088); end
      default:                 begin cls = CLS_PASS;  off = '0; end
    endcase
  end

  // every redirected slot is a whole 64-bit word (R1)
  always_comb begin
    if (cls == CLS_REDIR) begin
      a_r1_offset_aligned: assert (off[2:0] == 3'b000);
    end
  end

endmodule

// File: rtl/srr_base_reg.sv
module srr_base_reg #(
  parameter int ADDR_W    = 64,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] base_q
);

  localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << PAGE_BITS) - ADDR_W'(1);

  logic [ADDR_W-1:0] base_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_r <= '0;
    end else if (wr_en) begin
      base_r <= wr_data & ~LOW_MASK;
    end
  end

  assign base_q = base_r;

  a_r8_page_low_zero: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (base_q[PAGE_BITS-1:0] == '0) && (base_q[ADDR_W-1:PAGE_BITS] == $past(wr_data[ADDR_W-1:PAGE_BITS])));

endmodule

// File: rtl/sysreg_redirect.sv
module sysreg_redirect
  import srr_pkg::*;
#(
  parameter int ID_W      = REG_ID_W,
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 64,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_en,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_wdata,
  output logic [ADDR_W-1:0] base_q,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ID_W-1:0]   acc_id,
  input  logic              acc_write,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [1:0]        acc_ctx,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              trap_valid,
  output logic [ID_W:0]     trap_syndrome,
  output logic              pass_valid,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int OFF_W = PAGE_BITS;

  reg_cls_e          cls;
  logic [OFF_W-1:0]  off;
  seq_st_e           st;
  logic              accept;
  logic              from_guest_hyp;
  logic              do_redirect;
  logic              do_trap;

  srr_lookup #(.ID_W(ID_W), .OFF_W(OFF_W)) u_lookup (
    .reg_id (acc_id),
    .cls    (cls),
    .off    (off)
  );

  srr_base_reg #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_base (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (base_wr),
    .wr_data (base_wdata),
    .base_q  (base_q)
  );

  assign acc_ready      = (st == ST_IDLE);
  assign accept         = acc_valid && acc_ready;
  assign from_guest_hyp = (acc_ctx == CTX_GUEST_HYP);
  assign do_trap        = from_guest_hyp && ((cls == CLS_TRAP) || ((cls == CLS_REDIR) && !mode_en));
  assign do_redirect    = from_guest_hyp && (cls == CLS_REDIR) && mode_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      mem_valid     <= 1'b0;
      mem_we        <= 1'b0;
      mem_addr      <= '0;
      mem_wdata     <= '0;
      trap_valid    <= 1'b0;
      trap_syndrome <= '0;
      pass_valid    <= 1'b0;
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
    end else begin
      trap_valid <= 1'b0;
      pass_valid <= 1'b0;
      rsp_valid  <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            if (do_redirect) begin
              mem_valid <= 1'b1;
              mem_we    <= acc_write;
              mem_addr  <= base_q + ADDR_W'(off);
              mem_wdata <= acc_wdata;
              st        <= ST_MREQ;
            end else if (do_trap) begin
              trap_valid    <= 1'b1;
              trap_syndrome <= {acc_write, acc_id};
            end else begin
              pass_valid <= 1'b1;
            end
          end
        end
        ST_MREQ: begin
          if (mem_ready) begin
            mem_valid <= 1'b0;
            if (mem_we) begin
              rsp_valid <= 1'b1;
              st        <= ST_IDLE;
            end else begin
              st <= ST_RWAIT;
            end
          end
        end
        ST_RWAIT: begin
          if (mem_rvalid) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= mem_rdata;
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r12_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r4_trap_without_mem: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> !mem_valid);

  a_r7_single_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({trap_valid, pass_valid, rsp_valid}));

  a_r1_addr_word: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_addr[2:0] == 3'b000));

  a_r9_write_ack: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && mem_we) |=> (rsp_valid && acc_ready));

  a_r10_load_return: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RWAIT && mem_rvalid) |=> (rsp_valid && rsp_rdata == $past(mem_rdata)));

  a_r10_stall_requester: assert property (@(posedge clk) disable iff (rst)
    (mem_valid || st == ST_RWAIT) |-> !acc_ready);

endmodule

// File: tb/test_sysreg_redirect.sv
`timescale 1ns/1ps
module test_sysreg_redirect;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_en = 1'b0;
  logic        base_wr = 1'b0;
  logic [63:0] base_wdata = '0;
  logic [63:0] base_q;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [5:0]  acc_id = '0;
  logic        acc_write = 1'b0;
  logic [63:0] acc_wdata = '0;
  logic [1:0]  acc_ctx = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic [63:0] mem_addr;
  logic        mem_we;
  logic [63:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        trap_valid;
  logic [6:0]  trap_syndrome;
  logic        pass_valid;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;

  always #2.5 clk = ~clk;

  sysreg_redirect i_sysreg_redirect (
    .clk(clk), .rst(rst), .mode_en(mode_en), .base_wr(base_wr), .base_wdata(base_wdata),
    .base_q(base_q), .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_id(acc_id),
    .acc_write(acc_write), .acc_wdata(acc_wdata), .acc_ctx(acc_ctx), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .trap_valid(trap_valid),
    .trap_syndrome(trap_syndrome), .pass_valid(pass_valid), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  int n_checks = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // memory model and event monitor, sampled on the falling edge
  logic [63:0] bmem [512];
  bit          rd_pending = 0;
  logic [8:0]  rd_idx = '0;
  int          stall_left = 0;
  int          stall_seen = 0;
  int          stall_bad = 0;
  logic [63:0] stall_addr = '0;
  int          ev_mem = 0, ev_trap = 0, ev_pass = 0, ev_rsp = 0;
  logic [63:0] ev_addr = '0, ev_wdata = '0, ev_rdata = '0;
  logic        ev_we = 1'b0;
  logic [6:0]  ev_syn = '0;

  always @(negedge clk) begin
    if (rd_pending) begin
      mem_rvalid = 1'b1;
      mem_rdata  = bmem[rd_idx];
      rd_pending = 0;
    end else begin
      mem_rvalid = 1'b0;
    end
    if (trap_valid) begin ev_trap++; ev_syn = trap_syndrome; end
    if (pass_valid) ev_pass++;
    if (rsp_valid)  begin ev_rsp++; ev_rdata = rsp_rdata; end
    if (mem_valid && stall_left > 0) begin
      mem_ready = 1'b0;
      stall_left--;
      if (stall_seen == 0) stall_addr = mem_addr;
      else if (mem_addr != stall_addr) stall_bad++;
      if (acc_ready) stall_bad++;
      stall_seen++;
    end else begin
      mem_ready = 1'b1;
    end
    if (mem_valid && mem_ready) begin
      ev_mem++;
      ev_addr  = mem_addr;
      ev_we    = mem_we;
      ev_wdata = mem_wdata;
      if (mem_we) bmem[mem_addr[11:3]] = mem_wdata;
      else begin rd_pending = 1; rd_idx = mem_addr[11:3]; end
    end
  end

  task automatic clear_ev();
    ev_mem = 0; ev_trap = 0; ev_pass = 0; ev_rsp = 0;
  endtask

  task automatic access(input logic [1:0] ctx, input logic md, input logic wr,
                        input logic [5:0] id, input logic [63:0] wd);
    @(negedge clk);
    clear_ev();
    mode_en = md; acc_ctx = ctx; acc_write = wr; acc_id = id; acc_wdata = wd; acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // {ctx[2], mode, wr, id[6], kind[2] (0 pass, 1 mem, 2 trap), off[12]}
  localparam int NV = 15;
  localparam logic [23:0] VEC [NV] = '{
    {2'd2, 1'b1, 1'b0, 6'h01, 2'd1, 12'h110},  // R1 read
    {2'd2, 1'b1, 1'b1, 6'h02, 2'd1, 12'h200},  // R1 R9 write
    {2'd2, 1'b1, 1'b0, 6'h02, 2'd1, 12'h200},  // R10 read back stored word
    {2'd2, 1'b1, 1'b1, 6'h20, 2'd1, 12'h050},  // R2
    {2'd2, 1'b1, 1'b0, 6'h21, 2'd1, 12'h088},  // R2
    {2'd2, 1'b1, 1'b1, 6'h11, 2'd1, 12'h178},  // R3
    {2'd2, 1'b1, 1'b0, 6'h13, 2'd1, 12'h170},  // R3
    {2'd2, 1'b1, 1'b1, 6'h12, 2'd2, 12'h000},  // R4
    {2'd2, 1'b1, 1'b0, 6'h15, 2'd2, 12'h000},  // R4
    {2'd2, 1'b0, 1'b0, 6'h01, 2'd2, 12'h000},  // R5
    {2'd2, 1'b0, 1'b1, 6'h14, 2'd2, 12'h000},  // R5
    {2'd1, 1'b1, 1'b0, 6'h01, 2'd0, 12'h000},  // R7 kernel context
    {2'd3, 1'b1, 1'b1, 6'h11, 2'd0, 12'h000},  // R7 host context
    {2'd2, 1'b1, 1'b0, 6'h3F, 2'd0, 12'h000},  // R7 id not in table
    {2'd2, 1'b0, 1'b1, 6'h12, 2'd2, 12'h000}   // R4 with mode off
  };

  localparam logic [63:0] BASE_IN  = 64'h0000_0012_3456_7ABC;
  localparam logic [63:0] BASE_EXP = 64'h0000_0012_3456_7000;

  bit done = 0;

  initial begin
    for (int i = 0; i < 512; i++) bmem[i] = 64'hD00D_0000_0000_0000 | 64'(i);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(acc_ready == 1'b1, "R11 acc_ready in reset", 64'(acc_ready), 64'd1);
    chk({mem_valid, trap_valid, pass_valid, rsp_valid} == 4'b0, "R11 strobes in reset",
        64'({mem_valid, trap_valid, pass_valid, rsp_valid}), 64'd0);
    chk(base_q == '0, "R8 base after reset", base_q, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    base_wdata = BASE_IN; base_wr = 1'b1;
    @(negedge clk);
    base_wr = 1'b0;
    chk(base_q == BASE_EXP, "R8 base low bits zero", base_q, BASE_EXP);

    for (int v = 0; v < NV; v++) begin
      logic [63:0] wd;
      logic [63:0] ea;
      logic [63:0] er;
      wd = {32'hC0DE_0000, 24'h0, 8'(v)};
      ea = BASE_EXP + 64'(VEC[v][11:0]);
      er = bmem[ea[11:3]];
      access(VEC[v][23:22], VEC[v][21], VEC[v][20], VEC[v][19:14], wd);
      case (VEC[v][13:12])
        2'd1: begin  // R1 R2 R3 redirect
          chk(ev_mem == 1 && ev_addr == ea, $sformatf("R1 R2 R3 vec %0d address", v), ev_addr, ea);
          chk(ev_we == VEC[v][20] && ev_trap == 0 && ev_pass == 0 && ev_rsp == 1,
              $sformatf("R9 R10 vec %0d completion", v), 64'(ev_rsp), 64'd1);
          if (VEC[v][20])
            chk(ev_wdata == wd, $sformatf("R9 vec %0d store data", v), ev_wdata, wd);
          else
            chk(ev_rdata == er, $sformatf("R10 vec %0d load data", v), ev_rdata, er);
        end
        2'd2: begin  // R4 R5 R6 trap
          chk(ev_trap == 1 && ev_mem == 0 && ev_pass == 0 && ev_rsp == 0,
              $sformatf("R4 R5 vec %0d trap only", v), 64'(ev_mem), 64'd0);
          chk(ev_syn == {VEC[v][20], VEC[v][19:14]}, $sformatf("R6 vec %0d syndrome", v),
              64'(ev_syn), 64'({VEC[v][20], VEC[v][19:14]}));
        end
        default: begin  // R7 pass
          chk(ev_pass == 1 && ev_mem == 0 && ev_trap == 0 && ev_rsp == 0,
              $sformatf("R7 vec %0d pass only", v), 64'(ev_pass), 64'd1);
        end
      endcase
    end

    // R6 trap timing: pulse in the cycle after acceptance, then gone
    @(negedge clk);
    mode_en = 1'b1; acc_ctx = 2'd2; acc_write = 1'b0; acc_id = 6'h15; acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    chk(trap_valid == 1'b1 && trap_syndrome == 7'h15, "R6 trap pulse timing",
        64'({trap_valid, trap_syndrome}), 64'({1'b1, 7'h15}));
    @(negedge clk);
    chk(trap_valid == 1'b0, "R6 trap pulse one cycle", 64'(trap_valid), 64'd0);

    // R12 R10 stalled read of id 0x04 at offset 0x120
    begin
      logic [63:0] er;
      er = bmem[(BASE_EXP[11:3] + 9'(12'h120 >> 3))];
      stall_seen = 0; stall_bad = 0; stall_left = 3;
      access(2'd2, 1'b1, 1'b0, 6'h04, 64'd0);
      chk(stall_seen == 3 && stall_bad == 0, "R12 request held, requester stalled",
          64'(stall_bad), 64'd0);
      chk(ev_mem == 1 && ev_addr == BASE_EXP + 64'h120, "R1 stalled read address", ev_addr,
          BASE_EXP + 64'h120);
      chk(ev_rsp == 1 && ev_rdata == er, "R10 stalled read data", ev_rdata, er);
      chk(acc_ready == 1'b1, "R10 ready after completion", 64'(acc_ready), 64'd1);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

endmodule